// File: doc/BRIEF.md
# SPI Master Chip-Select Hold Controller

This block is an SPI master transmitter with four internal active-low chip-select lines. Software writes bytes into a one-word transmit holding register. From there each byte moves into an 8-bit shifter and goes out MSB first in SPI mode 0. SCK runs at one quarter of the system clock. The byte shifted in from MISO is kept in a receive data register.

The core of the block is the chip-select sequencing. Each chip-select has a configuration register with a "hold after transfer" bit.

- **Hold bit clear:** the selected line is driven low only while a byte is waiting or being shifted. It is released as soon as both stages are empty.
- **Hold bit set:** the line stays low between bytes. It is released only after an "end of sequence" flag has been raised and both the holding register and the shifter are empty. The flag can be raised through the control register or carried with a transmit word. It clears itself when the line is released, so it applies to one sequence only.

Software picks the target line through a select field in the control register. A status register and a read-only version register complete the register map.

Top module: `spi_cs_hold_ctrl`

## Requirements
- R1: After reset all four chip-select outputs are high and SCK is low. The status register (address 0x3) reads 0x3: bit 0 is holding register empty, bit 1 is holding register and shifter both empty, and bit 2 is receive ready, which reads 0.
- R2: Address 0xF reads 0x171 at all times, and writes to it have no effect.
- R3: Each byte written to the transmit register (address 0x1, data in bits 7:0) goes out MSB first. MOSI is stable while SCK is high, SCK toggles only while a chip-select is low, and SCK runs at the system clock divided by four.
- R4: The byte sampled from MISO on the SCK rising edges is readable at address 0x2. Status bit 2 sets when a byte completes and clears when address 0x2 is read.
- R5: At most one chip-select output is low at any time, and it is the line chosen by the control register select field (bits 5:4 of address 0x0) when the byte was written.
- R6: With the hold bit (bit 0 of address 0x4+n) clear for line n, the line is released when the holding register and the shifter are both empty. An end-of-sequence flag raised while the bit is clear is ignored and does not carry into a later held sequence.
- R7: With the hold bit set, the line stays low after all written bytes are done, as long as no end-of-sequence flag has been raised.
- R8: Writing 1 to control bit 0 raises the end-of-sequence flag. A held line is then released once the holding register and the shifter are both empty.
- R9: Bit 8 of a transmit write raises the end-of-sequence flag with that byte. The held line is released after that byte when no further byte is pending.
- R10: A byte written while another is shifting follows it with no chip-select release in between, even when the end-of-sequence flag has already been raised.
- R11: The end-of-sequence flag clears when the line is released, so the next sequence on a held line stays asserted.
- R12: When a byte is queued for a different line than the one currently held, the held line is released for at least one cycle before the new line asserts.
- R13: Status bit 1 reads 0 while a byte is queued or shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip-selects |

## Verification
The hardest situation to reach is an end-of-sequence flag raised while a held line is mid-byte, with the next byte arriving just before the shifter drains. In that case the release must wait for the second byte.

The stimulus reaches this case by polling the holding-register-empty bit. It issues the control write and the follow-up transmit write inside the 32-cycle window of a single byte. It then counts chip-select release events.

A flag sent on an unheld line, followed by a held sequence on that same line, covers the case where the flag must be ignored. Randomized bytes spread over randomly chosen lines exercise the data path.

// File: rtl/spi_csh_pkg.sv
package spi_csh_pkg;
  localparam int CSH_NUM_CS  = 4;
  localparam int CSH_WORD_W  = 8;
  localparam int CSH_ADDR_W  = 4;
  localparam int CSH_DATA_W  = 32;
  localparam int CSH_SCK_DIV = 4;
  localparam logic [11:0] CSH_VERSION = 12'h171;

  // register word addresses
  localparam int CSH_A_CTRL = 0;
  localparam int CSH_A_TXD  = 1;
  localparam int CSH_A_RXD  = 2;
  localparam int CSH_A_STAT = 3;
  localparam int CSH_A_CFG  = 4;
  localparam int CSH_A_VER  = 15;

  // field positions
  localparam int CSH_CTRL_END_BIT = 0;
  localparam int CSH_CTRL_SEL_LSB = 4;
  localparam int CSH_TXD_END_BIT  = 8;
  localparam int CSH_CFG_HOLD_BIT = 0;
  localparam int CSH_ST_TXE_BIT   = 0;
  localparam int CSH_ST_IDLE_BIT  = 1;
  localparam int CSH_ST_RXR_BIT   = 2;
endpackage

// File: rtl/spi_csh_regs.sv
module spi_csh_regs
  import spi_csh_pkg::*;
#(
  parameter int NUM_CS = CSH_NUM_CS,
  parameter int WORD_W = CSH_WORD_W,
  parameter int ADDR_W = CSH_ADDR_W,
  parameter int DATA_W = CSH_DATA_W,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_full,
  input  logic              shift_busy,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_strobe,
  output logic [CS_W-1:0]   sel_q,
  output logic [NUM_CS-1:0] hold_q,
  output logic              end_raise,
  output logic              tx_wr,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_end
);
  logic              wr_en, rd_en, ctrl_wr, rxd_rd;
  logic [CS_W-1:0]   sel_d, wsel;
  logic [NUM_CS-1:0] hold_d;
  logic [WORD_W-1:0] rx_data_q, rx_data_d;
  logic              rx_rdy_q, rx_rdy_d;

  assign wr_en   = bus_en & bus_we;
  assign rd_en   = bus_en & ~bus_we;
  assign ctrl_wr = wr_en && (bus_addr == ADDR_W'(CSH_A_CTRL));
  assign rxd_rd  = rd_en && (bus_addr == ADDR_W'(CSH_A_RXD));
  assign wsel    = bus_wdata[CSH_CTRL_SEL_LSB +: CS_W];

  // end-of-sequence requests only count for a line in hold mode
  assign end_raise = ctrl_wr && bus_wdata[CSH_CTRL_END_BIT] && hold_q[wsel];
  assign tx_wr     = wr_en && (bus_addr == ADDR_W'(CSH_A_TXD));
  assign tx_word   = bus_wdata[WORD_W-1:0];
  assign tx_end    = bus_wdata[CSH_TXD_END_BIT] && hold_q[sel_q];

  always_comb begin
    sel_d = sel_q;
    if (ctrl_wr) sel_d = wsel;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cfg
    logic cfg_wr;
    assign cfg_wr = wr_en && (bus_addr == ADDR_W'(CSH_A_CFG + i));
    always_comb begin
      hold_d[i] = hold_q[i];
      if (cfg_wr) hold_d[i] = bus_wdata[CSH_CFG_HOLD_BIT];
    end
  end

  always_comb begin
    rx_data_d = rx_data_q;
    rx_rdy_d  = rx_rdy_q;
    if (rx_strobe) begin
      rx_data_d = rx_word;
      rx_rdy_d  = 1'b1;
    end else if (rxd_rd) begin
      rx_rdy_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      hold_q    <= '0;
      rx_data_q <= '0;
      rx_rdy_q  <= 1'b0;
    end else begin
      sel_q     <= sel_d;
      hold_q    <= hold_d;
      rx_data_q <= rx_data_d;
      rx_rdy_q  <= rx_rdy_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CSH_A_CTRL)) begin
      bus_rdata[CSH_CTRL_SEL_LSB +: CS_W] = sel_q;
    end else if (bus_addr == ADDR_W'(CSH_A_RXD)) begin
      bus_rdata[WORD_W-1:0] = rx_data_q;
    end else if (bus_addr == ADDR_W'(CSH_A_STAT)) begin
      bus_rdata[CSH_ST_TXE_BIT]  = ~tx_full;
      bus_rdata[CSH_ST_IDLE_BIT] = ~tx_full & ~shift_busy;
      bus_rdata[CSH_ST_RXR_BIT]  = rx_rdy_q;
    end else if (bus_addr == ADDR_W'(CSH_A_VER)) begin
      bus_rdata[11:0] = CSH_VERSION;
    end else begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (bus_addr == ADDR_W'(CSH_A_CFG + i)) bus_rdata[CSH_CFG_HOLD_BIT] = hold_q[i];
      end
    end
  end
endmodule

// File: rtl/spi_csh_shifter.sv
module spi_csh_shifter
  import spi_csh_pkg::*;
#(
  parameter int WORD_W  = CSH_WORD_W,
  parameter int SCK_DIV = CSH_SCK_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] start_word,
  input  logic              miso,
  output logic              busy,
  output logic              word_end,
  output logic              sck,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);
  localparam int DIV_W = $clog2(SCK_DIV);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int HALF  = SCK_DIV / 2;

  logic              busy_q, busy_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [WORD_W-1:0] tx_sh_q, tx_sh_d, rx_sh_q, rx_sh_d;
  logic              period_end, sample_now;

  assign period_end = busy_q && (div_q == DIV_W'(SCK_DIV - 1));
  assign sample_now = busy_q && (div_q == DIV_W'(HALF));
  assign word_end   = period_end && (bit_q == BIT_W'(WORD_W - 1));

  always_comb begin
    busy_d  = busy_q;
    div_d   = div_q;
    bit_d   = bit_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    if (sample_now) rx_sh_d = {rx_sh_q[WORD_W-2:0], miso};
    if (start) begin
      busy_d  = 1'b1;
      div_d   = '0;
      bit_d   = '0;
      tx_sh_d = start_word;
    end else if (busy_q) begin
      if (period_end) begin
        div_d = '0;
        if (word_end) begin
          busy_d = 1'b0;
        end else begin
          bit_d   = bit_q + 1'b1;
          tx_sh_d = {tx_sh_q[WORD_W-2:0], 1'b0};
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else begin
      busy_q  <= busy_d;
      div_q   <= div_d;
      bit_q   <= bit_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
    end
  end

  assign busy    = busy_q;
  assign sck     = busy_q && (div_q >= DIV_W'(HALF));
  assign mosi    = tx_sh_q[WORD_W-1];
  assign rx_word = rx_sh_q;
endmodule

// File: rtl/spi_csh_cs_seq.sv
module spi_csh_cs_seq
  import spi_csh_pkg::*;
#(
  parameter int NUM_CS = CSH_NUM_CS,
  parameter int WORD_W = CSH_WORD_W,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CS_W-1:0]   sel,
  input  logic [NUM_CS-1:0] hold_vec,
  input  logic              end_raise,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_end,
  input  logic              shift_busy,
  input  logic              word_end,
  output logic              start,
  output logic [WORD_W-1:0] start_word,
  output logic              tx_full,
  output logic [NUM_CS-1:0] cs_n
);
  logic              full_q, full_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [CS_W-1:0]   wcs_q, wcs_d;
  logic              act_q, act_d;
  logic [CS_W-1:0]   idx_q, idx_d;
  logic              end_q, end_d;
  logic              shift_free, same_line, can_load, release_now, accept;

  assign shift_free  = ~shift_busy | word_end;
  assign same_line   = ~act_q | (idx_q == wcs_q);
  assign can_load    = full_q & shift_free & same_line;
  // release: line switch pending, or nothing left and no reason to hold
  assign release_now = act_q & shift_free & ~can_load &
                       (full_q | ~hold_vec[idx_q] | end_q);
  assign accept      = tx_wr & (~full_q | can_load);

  always_comb begin
    full_d = (full_q & ~can_load) | accept;
    word_d = word_q;
    wcs_d  = wcs_q;
    if (accept) begin
      word_d = tx_word;
      wcs_d  = sel;
    end
    act_d = act_q;
    idx_d = idx_q;
    if (can_load) begin
      act_d = 1'b1;
      idx_d = wcs_q;
    end else if (release_now) begin
      act_d = 1'b0;
    end
    end_d = end_q;
    if (end_raise || (accept && tx_end)) end_d = 1'b1;
    else if (release_now)                end_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      word_q <= '0;
      wcs_q  <= '0;
      act_q  <= 1'b0;
      idx_q  <= '0;
      end_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      word_q <= word_d;
      wcs_q  <= wcs_d;
      act_q  <= act_d;
      idx_q  <= idx_d;
      end_q  <= end_d;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = ~(act_q && (idx_q == CS_W'(i)));
  end

  assign start      = can_load;
  assign start_word = word_q;
  assign tx_full    = full_q;
endmodule

// File: rtl/spi_cs_hold_ctrl.sv
module spi_cs_hold_ctrl
  import spi_csh_pkg::*;
#(
  parameter int NUM_CS  = CSH_NUM_CS,
  parameter int WORD_W  = CSH_WORD_W,
  parameter int ADDR_W  = CSH_ADDR_W,
  parameter int DATA_W  = CSH_DATA_W,
  parameter int SCK_DIV = CSH_SCK_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int CS_W = $clog2(NUM_CS);

  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [CS_W-1:0]   sel_q;
  logic [NUM_CS-1:0] hold_q;
  logic              end_raise, tx_wr, tx_end, tx_full;
  logic [WORD_W-1:0] tx_word, start_word, rx_word;
  logic              start, shift_busy, word_end;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  spi_csh_regs #(
    .NUM_CS(NUM_CS), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_int),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_full(tx_full), .shift_busy(shift_busy),
    .rx_word(rx_word), .rx_strobe(word_end),
    .sel_q(sel_q), .hold_q(hold_q), .end_raise(end_raise),
    .tx_wr(tx_wr), .tx_word(tx_word), .tx_end(tx_end)
  );

  spi_csh_cs_seq #(
    .NUM_CS(NUM_CS), .WORD_W(WORD_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_int),
    .sel(sel_q), .hold_vec(hold_q), .end_raise(end_raise),
    .tx_wr(tx_wr), .tx_word(tx_word), .tx_end(tx_end),
    .shift_busy(shift_busy), .word_end(word_end),
    .start(start), .start_word(start_word),
    .tx_full(tx_full), .cs_n(spi_cs_n)
  );

  spi_csh_shifter #(
    .WORD_W(WORD_W), .SCK_DIV(SCK_DIV)
  ) u_shift (
    .clk(clk), .rst_n(rst_n_int),
    .start(start), .start_word(start_word), .miso(spi_miso),
    .busy(shift_busy), .word_end(word_end),
    .sck(spi_sck), .mosi(spi_mosi), .rx_word(rx_word)
  );
endmodule

// File: rtl/spi_csh_chk.sv
module spi_csh_chk #(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic [NUM_CS-1:0] spi_cs_n
);
  AST_CS_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n)); // R5

  AST_SCK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> (spi_cs_n != '1)); // R3

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi)); // R3

  AST_CS_BREAK_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((spi_cs_n != '1) && ($past(spi_cs_n) != '1)) |-> (spi_cs_n == $past(spi_cs_n))); // R12

  AST_VERSION_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && (bus_addr == ADDR_W'(15))) |-> (bus_rdata == DATA_W'(32'h171))); // R2
endmodule

bind spi_cs_hold_ctrl spi_csh_chk #(
  .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/spi_cs_hold_ctrl_tb.sv
`timescale 1ns/1ps
module spi_cs_hold_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        spi_sck, spi_mosi, spi_miso;
  logic [3:0]  spi_cs_n;

  always #2.5 clk = ~clk;

  spi_cs_hold_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  int n_chk = 0, n_bad = 0;

  // bench SPI slave model, sampled away from the active edge
  logic [7:0] slave_byte = 8'h00;
  logic [7:0] mosi_sh = 8'h00;
  int         s_bits = 0, m_bits = 0;
  logic       sck_prev = 1'b0;
  logic [3:0] cs_prev = 4'hF;
  logic [7:0] cap_data [0:255];
  int         cap_cs   [0:255];
  int         cap_n = 0, rel_events = 0, overlap = 0;

  function automatic int low_index(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (!v[i]) return i;
    return -1;
  endfunction

  assign spi_miso = slave_byte[3'(7 - (s_bits % 8))];

  always @(negedge clk) begin
    if ($countones(~spi_cs_n) > 1) overlap++;
    if (spi_cs_n == 4'hF && cs_prev != 4'hF) rel_events++;
    if (spi_cs_n == 4'hF) begin
      s_bits <= 0;
      m_bits <= 0;
    end else begin
      if (spi_sck && !sck_prev) begin
        if (m_bits == 7) begin
          cap_data[cap_n[7:0]] <= {mosi_sh[6:0], spi_mosi};
          cap_cs[cap_n[7:0]]   <= low_index(spi_cs_n);
          cap_n  <= cap_n + 1;
          m_bits <= 0;
        end else begin
          m_bits <= m_bits + 1;
        end
        mosi_sh <= {mosi_sh[6:0], spi_mosi};
      end
      if (!spi_sck && sck_prev) s_bits <= s_bits + 1;
    end
    sck_prev <= spi_sck;
    cs_prev  <= spi_cs_n;
  end

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    st = '0;
    while (!st[1]) bus_read(4'h3, st);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_txe();
    logic [31:0] st;
    st = '0;
    while (!st[0]) bus_read(4'h3, st);
  endtask

  function automatic logic [31:0] ctrl_word(input int sel, input bit fin);
    return (32'(sel) << 4) | 32'(fin);
  endfunction

  task automatic check_last(input string req, input logic [7:0] d, input int cs);
    check_eq({req, " data"}, 32'(cap_data[8'(cap_n - 1)]), 32'(d));
    check_eq({req, " line"}, 32'(cap_cs[8'(cap_n - 1)]), 32'(cs));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [7:0]  w [0:2];
    int          r0, n0;
    rv = $urandom(32'd1234);
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_eq("R1 cs_n", 32'(spi_cs_n), 32'hF);
    check_eq("R1 sck", 32'(spi_sck), 32'h0);
    bus_read(4'h3, rv); check_eq("R1 status", rv, 32'h3);

    // R2 version
    bus_read(4'hF, rv); check_eq("R2 version", rv, 32'h171);
    bus_write(4'hF, 32'h0); bus_read(4'hF, rv); check_eq("R2 version after write", rv, 32'h171);

    // R3/R4/R13 single byte, line 0, no hold
    slave_byte = 8'h3C;
    bus_write(4'h1, 32'hA5);
    bus_read(4'h3, rv); check_eq("R13 busy status", 32'(rv[1]), 32'h0);
    wait_idle();
    check_last("R3", 8'hA5, 0);
    check_eq("R6 released", 32'(spi_cs_n), 32'hF);
    bus_read(4'h3, rv); check_eq("R4 rx ready", 32'(rv[2]), 32'h1);
    bus_read(4'h2, rv); check_eq("R4 rx data", rv, 32'h3C);
    bus_read(4'h3, rv); check_eq("R4 rx ready cleared", 32'(rv[2]), 32'h0);

    // R6 end flag ignored without hold, must not carry into held sequence
    bus_write(4'h1, 32'h111);
    wait_idle();
    check_eq("R6 unheld release", 32'(spi_cs_n), 32'hF);
    bus_write(4'h4, 32'h1);
    bus_write(4'h1, 32'h22);
    wait_idle(); repeat (20) @(negedge clk);
    check_eq("R6 stale flag ignored", 32'(spi_cs_n), 32'hE);
    bus_write(4'h0, ctrl_word(0, 1'b1));
    repeat (4) @(negedge clk);
    check_eq("R8 ctrl end releases", 32'(spi_cs_n), 32'hF);

    // R7/R9/R11 held line 1
    bus_write(4'h5, 32'h1);
    bus_write(4'h0, ctrl_word(1, 1'b0));
    bus_write(4'h1, 32'h5A);
    wait_idle(); repeat (16) @(negedge clk);
    check_eq("R7 held after byte", 32'(spi_cs_n), 32'hD);
    bus_write(4'h1, 32'h1C3);
    wait_idle();
    check_eq("R9 data-flag release", 32'(spi_cs_n), 32'hF);
    check_last("R9", 8'hC3, 1);
    bus_write(4'h1, 32'h77);
    wait_idle(); repeat (8) @(negedge clk);
    check_eq("R11 flag self-cleared", 32'(spi_cs_n), 32'hD);

    // R12 switch from held line 1 to line 3
    bus_write(4'h0, ctrl_word(3, 1'b0));
    bus_write(4'h1, 32'h99);
    wait_idle();
    check_last("R12", 8'h99, 3);
    check_eq("R12 both released", 32'(spi_cs_n), 32'hF);

    // R10 end flag raised mid-byte, next byte arrives in time
    bus_write(4'h0, ctrl_word(1, 1'b0));
    r0 = rel_events; n0 = cap_n;
    bus_write(4'h1, 32'h4E);
    bus_write(4'h0, ctrl_word(1, 1'b1));
    wait_txe();
    bus_write(4'h1, 32'hB1);
    wait_idle();
    check_eq("R10 one release", 32'(rel_events - r0), 32'h1);
    check_eq("R10 two bytes", 32'(cap_n - n0), 32'h2);
    check_last("R10", 8'hB1, 1);

    // R10 burst of three on unheld line 2
    bus_write(4'h0, ctrl_word(2, 1'b0));
    r0 = rel_events; n0 = cap_n;
    for (int k = 0; k < 3; k++) begin
      w[k] = 8'($urandom);
      wait_txe();
      bus_write(4'h1, 32'(w[k]));
    end
    wait_idle();
    check_eq("R10 burst one release", 32'(rel_events - r0), 32'h1);
    for (int k = 0; k < 3; k++)
      check_eq("R10 burst data", 32'(cap_data[8'(n0 + k)]), 32'(w[k]));

    // random single bytes over random unheld lines
    bus_write(4'h4, 32'h0); bus_write(4'h5, 32'h0);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d;
      int         cs;
      d  = 8'($urandom);
      cs = int'($urandom % 4);
      slave_byte = 8'($urandom);
      bus_write(4'h0, ctrl_word(cs, 1'($urandom)));
      bus_write(4'h1, {23'h0, 1'($urandom), d});
      wait_idle();
      check_last("R5 random", d, cs);
      check_eq("R6 random release", 32'(spi_cs_n), 32'hF);
      bus_read(4'h2, rv); check_eq("R4 random rx", rv, 32'(slave_byte));
    end

    check_eq("R5 no overlap", 32'(overlap), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule